// File: doc/BRIEF.md
# KCS Interface Register Port

This block holds the registers of a single IPMI Keyboard Controller Style channel and serves two masters. The host sees two byte-wide I/O ports at a programmable base address. The data port is at the base, and the command/status port is at the base plus one. A host write to either port fills the input register. A host read of the data port drains the output register, and a host read of the command/status port returns the status byte. Decoding the host bus cycle into address, strobes and data is done before this block.

The local management controller reaches the same channel through a small register bus. It reads received bytes from the input data register and writes reply bytes into the output data register. It also reads the status register and writes the two-bit protocol state field in it. An interrupt output follows the input-full flag while the interrupt enable input is high. This lets the controller service the channel on each host byte and tell control codes from payload by the command/data flag.

Top module: `kcs_port`

## Requirements
- R1: After reset the status byte reads 0x00: the state field is idle, IBF, OBF and C/D are all clear, and irq is low.
- R2: A host write to the data port (hostAddr equal to baseAddr) latches the byte into the input register, sets IBF (status bit 1) and clears C/D (status bit 3).
- R3: A host write to the command port (hostAddr equal to baseAddr plus one) latches the byte into the input register, sets IBF and sets C/D.
- R4: A controller read at local address 0 returns the input register and clears IBF on the following clock edge. If a host write lands in the same cycle, IBF stays set and the new byte is kept.
- R5: A controller write at local address 1 loads the output register and sets OBF (status bit 0). A host read of the data port returns that byte and clears OBF. If a controller write lands in the same cycle, OBF stays set.
- R6: A host read of the command port returns the status byte with no side effect. In that byte, bits 7:6 are the state, bit 3 is C/D, bit 1 is IBF, bit 0 is OBF, and bits 5, 4 and 2 read 0.
- R7: A controller write at local address 2 copies only data bits 7:6 into the state field (0 idle, 1 read, 2 write, 3 error). The flags are left unchanged.
- R8: A host write while IBF is still set overwrites the input register and updates C/D to match the port written. IBF stays set.
- R9: irq is high exactly when IBF is set and irqEnable was high at the last clock edge. It changes on the same edge as IBF.
- R10: While chanEnable is low, host writes change nothing. Host reads return 0xFF and do not clear OBF.
- R11: Host cycles at addresses other than baseAddr and baseAddr plus one have no effect, and a new baseAddr takes effect at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chanEnable | input | 1 | Accept host cycles when high |
| irqEnable | input | 1 | Enable the input-full interrupt |
| baseAddr | input | HOST_AW | Host address of the data port |
| hostAddr | input | HOST_AW | Host cycle address |
| hostWrEn | input | 1 | Host write strobe, one cycle |
| hostRdEn | input | 1 | Host read strobe, one cycle |
| hostWrData | input | 8 | Host write byte |
| hostRdData | output | 8 | Host read byte for the current address |
| locAddr | input | LOC_AW | Local register select |
| locWrEn | input | 1 | Local write strobe |
| locRdEn | input | 1 | Local read strobe |
| locWrData | input | 8 | Local write byte |
| locRdData | output | 8 | Local read byte for the current select |
| irq | output | 1 | Input-full interrupt |

## Verification
The hardest cases to reach are the same-cycle collisions: a host write that meets a controller read of the input register, and a controller output write that meets a host data read. The set must win in both. The bench raises both strobes on the same falling edge, so the two sides act on one rising edge. It then reads the flags back through the status register and checks which byte was kept. The status field is also walked through the error, read and write states while flags are set, to show that a state write leaves the flag bits alone.

// File: rtl/kcs_port_pkg.sv
package kcs_port_pkg;

  localparam int unsigned BYTE_W = 8;

  // local register select codes
  localparam int unsigned LOC_IDR = 0;
  localparam int unsigned LOC_ODR = 1;
  localparam int unsigned LOC_STS = 2;

  // status byte bit positions
  localparam int unsigned STS_OBF = 0;
  localparam int unsigned STS_IBF = 1;
  localparam int unsigned STS_CD  = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_ERROR = 2'd3
  } ifState_e;

  typedef struct packed {
    logic selData;   // host address hits data port (enabled)
    logic selCmd;    // host address hits command port (enabled)
    logic dataWr;
    logic cmdWr;
    logic dataRd;
    logic idrRd;
    logic odrWr;
    logic stsWr;
  } kcsStrobe_t;

endpackage

// File: rtl/kcs_port_ctrl.sv
module kcs_port_ctrl
  import kcs_port_pkg::*;
#(
  parameter int unsigned HOST_AW = 16,
  parameter int unsigned LOC_AW  = 2
) (
  input  logic               chanEnable,
  input  logic [HOST_AW-1:0] baseAddr,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               hostWrEn,
  input  logic               hostRdEn,
  input  logic [LOC_AW-1:0]  locAddr,
  input  logic               locWrEn,
  input  logic               locRdEn,
  output kcsStrobe_t         strobe
);

  logic [HOST_AW-1:0] cmdAddr;
  logic hitData, hitCmd;

  assign cmdAddr = baseAddr + HOST_AW'(1);
  assign hitData = chanEnable && (hostAddr == baseAddr);
  assign hitCmd  = chanEnable && (hostAddr == cmdAddr);

  always_comb begin
    strobe         = '0;
    strobe.selData = hitData;
    strobe.selCmd  = hitCmd;
    strobe.dataWr  = hitData && hostWrEn;
    strobe.cmdWr   = hitCmd  && hostWrEn;
    strobe.dataRd  = hitData && hostRdEn;
    strobe.idrRd   = locRdEn && (locAddr == LOC_AW'(LOC_IDR));
    strobe.odrWr   = locWrEn && (locAddr == LOC_AW'(LOC_ODR));
    strobe.stsWr   = locWrEn && (locAddr == LOC_AW'(LOC_STS));
  end

endmodule

// File: rtl/kcs_port_datapath.sv
module kcs_port_datapath
  import kcs_port_pkg::*;
#(
  parameter int unsigned LOC_AW = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  kcsStrobe_t        strobe,
  input  logic              irqEnable,
  input  logic [BYTE_W-1:0] hostWrData,
  input  logic [BYTE_W-1:0] locWrData,
  input  logic [LOC_AW-1:0] locAddr,
  output logic [BYTE_W-1:0] hostRdData,
  output logic [BYTE_W-1:0] locRdData,
  output logic [BYTE_W-1:0] statusByte,
  output logic              irq
);

  localparam logic [BYTE_W-1:0] FLOAT_BYTE = '1;

  logic [BYTE_W-1:0] inReg, outReg;
  logic ibf, obf, cmdFlag;
  ifState_e ifState;
  logic ibfNext, obfNext;
  logic hostWr;

  assign hostWr = strobe.dataWr || strobe.cmdWr;

  // sets take priority over clears on both flags
  always_comb begin
    ibfNext = ibf;
    if (hostWr)            ibfNext = 1'b1;
    else if (strobe.idrRd) ibfNext = 1'b0;
    obfNext = obf;
    if (strobe.odrWr)       obfNext = 1'b1;
    else if (strobe.dataRd) obfNext = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inReg   <= '0;
      outReg  <= '0;
      ibf     <= 1'b0;
      obf     <= 1'b0;
      cmdFlag <= 1'b0;
      ifState <= ST_IDLE;
      irq     <= 1'b0;
    end else begin
      ibf <= ibfNext;
      obf <= obfNext;
      irq <= ibfNext && irqEnable;
      if (hostWr) begin
        inReg   <= hostWrData;
        cmdFlag <= strobe.cmdWr;
      end
      if (strobe.odrWr) outReg <= locWrData;
      if (strobe.stsWr) ifState <= ifState_e'(locWrData[BYTE_W-1 -: 2]);
    end
  end

  always_comb begin
    statusByte          = '0;
    statusByte[BYTE_W-1 -: 2] = ifState;
    statusByte[STS_CD]  = cmdFlag;
    statusByte[STS_IBF] = ibf;
    statusByte[STS_OBF] = obf;
  end

  always_comb begin
    if (strobe.selData)     hostRdData = outReg;
    else if (strobe.selCmd) hostRdData = statusByte;
    else                    hostRdData = FLOAT_BYTE;
  end

  always_comb begin
    case (locAddr)
      LOC_AW'(LOC_IDR): locRdData = inReg;
      LOC_AW'(LOC_ODR): locRdData = outReg;
      LOC_AW'(LOC_STS): locRdData = statusByte;
      default:          locRdData = '0;
    endcase
  end

endmodule

// File: rtl/kcs_port.sv
module kcs_port
  import kcs_port_pkg::*;
#(
  parameter int unsigned HOST_AW = 16,
  parameter int unsigned LOC_AW  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               chanEnable,
  input  logic               irqEnable,
  input  logic [HOST_AW-1:0] baseAddr,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               hostWrEn,
  input  logic               hostRdEn,
  input  logic [7:0]         hostWrData,
  output logic [7:0]         hostRdData,
  input  logic [LOC_AW-1:0]  locAddr,
  input  logic               locWrEn,
  input  logic               locRdEn,
  input  logic [7:0]         locWrData,
  output logic [7:0]         locRdData,
  output logic               irq
);

  kcsStrobe_t strobe;
  logic [BYTE_W-1:0] statusByte;

  kcs_port_ctrl #(.HOST_AW(HOST_AW), .LOC_AW(LOC_AW)) u_ctrl (
    .chanEnable(chanEnable),
    .baseAddr  (baseAddr),
    .hostAddr  (hostAddr),
    .hostWrEn  (hostWrEn),
    .hostRdEn  (hostRdEn),
    .locAddr   (locAddr),
    .locWrEn   (locWrEn),
    .locRdEn   (locRdEn),
    .strobe    (strobe)
  );

  kcs_port_datapath #(.LOC_AW(LOC_AW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .irqEnable (irqEnable),
    .hostWrData(hostWrData),
    .locWrData (locWrData),
    .locAddr   (locAddr),
    .hostRdData(hostRdData),
    .locRdData (locRdData),
    .statusByte(statusByte),
    .irq       (irq)
  );

endmodule

// File: rtl/kcs_port_checker.sv
module kcs_port_checker #(
  parameter int unsigned HOST_AW = 16,
  parameter int unsigned LOC_AW  = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               chanEnable,
  input logic [HOST_AW-1:0] baseAddr,
  input logic [HOST_AW-1:0] hostAddr,
  input logic               hostWrEn,
  input logic               hostRdEn,
  input logic [LOC_AW-1:0]  locAddr,
  input logic               locWrEn,
  input logic               locRdEn,
  input logic [7:0]         locWrData,
  input logic [7:0]         hostRdData,
  input logic [7:0]         status,
  input logic               irq
);

  logic [HOST_AW-1:0] nextAddr;
  logic dataHit, cmdHit;
  assign nextAddr = baseAddr + HOST_AW'(1);
  assign dataHit  = chanEnable && hostAddr == baseAddr;
  assign cmdHit   = chanEnable && hostAddr == nextAddr;

  p_data_wr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (dataHit && hostWrEn) |=> (status[1] && !status[3]));

  p_cmd_wr_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdHit && hostWrEn) |=> (status[1] && status[3]));

  p_idr_rd_r4: assert property (@(posedge clk) disable iff (!rstN)
    (locRdEn && locAddr == LOC_AW'(0) && !((dataHit || cmdHit) && hostWrEn))
    |=> !status[1]);

  p_reserved_r6: assert property (@(posedge clk) disable iff (!rstN)
    (status[5:4] == 2'b00 && !status[2]));

  p_sts_wr_r7: assert property (@(posedge clk) disable iff (!rstN)
    (locWrEn && locAddr == LOC_AW'(2) && !hostWrEn && !hostRdEn && !locRdEn)
    |=> (status[7:6] == $past(locWrData[7:6]) && status[5:0] == $past(status[5:0])));

  p_irq_ibf_r9: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> status[1]);

  p_off_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!chanEnable && !locWrEn && !locRdEn) |=> $stable(status));

  p_off_float_r10: assert property (@(posedge clk) disable iff (!rstN)
    !chanEnable |-> hostRdData == 8'hFF);

endmodule

bind kcs_port kcs_port_checker #(.HOST_AW(HOST_AW), .LOC_AW(LOC_AW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .chanEnable(chanEnable),
  .baseAddr  (baseAddr),
  .hostAddr  (hostAddr),
  .hostWrEn  (hostWrEn),
  .hostRdEn  (hostRdEn),
  .locAddr   (locAddr),
  .locWrEn   (locWrEn),
  .locRdEn   (locRdEn),
  .locWrData (locWrData),
  .hostRdData(hostRdData),
  .status    (statusByte),
  .irq       (irq)
);

// File: tb/kcs_port_test.sv
`timescale 1ns/1ps
module kcs_port_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chanEnable = 1'b1, irqEnable = 1'b0;
  logic [15:0] baseAddr = 16'h0CA2, hostAddr = 16'h0;
  logic hostWrEn = 1'b0, hostRdEn = 1'b0;
  logic [7:0] hostWrData = 8'h0, hostRdData;
  logic [1:0] locAddr = 2'd0;
  logic locWrEn = 1'b0, locRdEn = 1'b0;
  logic [7:0] locWrData = 8'h0, locRdData;
  logic irq;

  always #2 clk = ~clk;  // 250 MHz

  kcs_port uut (
    .clk(clk), .rstN(rstN), .chanEnable(chanEnable), .irqEnable(irqEnable),
    .baseAddr(baseAddr), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostRdEn(hostRdEn), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .locAddr(locAddr), .locWrEn(locWrEn), .locRdEn(locRdEn),
    .locWrData(locWrData), .locRdData(locRdData), .irq(irq)
  );

  typedef struct {
    string      tag;
    logic [7:0] exp;
  } expItem_t;

  expItem_t   expQ[$];
  logic [7:0] actQ[$];
  event       pushEv;
  int         testsRun = 0;
  int         testsFailed = 0;
  bit         done = 1'b0;

  // scoreboard monitor
  initial begin
    forever begin
      @(pushEv);
      while (actQ.size() > 0 && expQ.size() > 0) begin
        expItem_t e;
        logic [7:0] a;
        e = expQ.pop_front();
        a = actQ.pop_front();
        testsRun++;
        if (a !== e.exp) begin
          testsFailed++;
          $display("FAIL %s: actual %02h expected %02h", e.tag, a, e.exp);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    expQ.push_back('{tag, exp});
    actQ.push_back(act);
    -> pushEv;
  endtask

  task automatic hostWr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostWrData = d; hostWrEn = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic hostRd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostRdEn = 1'b1;
    #1 d = hostRdData;
    @(negedge clk);
    hostRdEn = 1'b0;
  endtask

  task automatic locWr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    locAddr = a; locWrData = d; locWrEn = 1'b1;
    @(negedge clk);
    locWrEn = 1'b0;
  endtask

  task automatic locRd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    locAddr = a; locRdEn = 1'b1;
    #1 d = locRdData;
    @(negedge clk);
    locRdEn = 1'b0;
  endtask

  task automatic stsChk(input string tag, input logic [7:0] exp);
    logic [7:0] v;
    locRd(2'd2, v);
    chk(tag, v, exp);
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      testsFailed++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    stsChk("R1 status after reset", 8'h00);
    chk("R1 irq after reset", {7'd0, irq}, 8'h00);

    hostWr(16'h0CA2, 8'h11);
    stsChk("R2 data write sets IBF, C/D 0", 8'h02);
    locRd(2'd0, v);
    chk("R2 input register byte", v, 8'h11);
    stsChk("R4 IDR read clears IBF", 8'h00);

    hostWr(16'h0CA3, 8'h61);
    stsChk("R3 cmd write sets IBF and C/D", 8'h0A);
    hostRd(16'h0CA3, v);
    chk("R6 host status read", v, 8'h0A);
    stsChk("R6 status read no side effect", 8'h0A);

    hostWr(16'h0CA2, 8'h22);
    stsChk("R8 overrun keeps IBF, C/D 0", 8'h02);
    locRd(2'd0, v);
    chk("R8 overrun byte", v, 8'h22);

    locWr(2'd2, 8'hFF);
    stsChk("R7 state error only bits 7:6", 8'hC0);
    locWr(2'd2, 8'h7F);
    stsChk("R7 state read", 8'h40);
    hostWr(16'h0CA3, 8'h62);
    stsChk("R3 cmd write in read state", 8'h4A);
    locWr(2'd2, 8'h80);
    stsChk("R7 state write keeps flags", 8'h8A);
    locRd(2'd0, v);
    chk("R4 IDR byte", v, 8'h62);
    stsChk("R4 IBF clear, C/D kept", 8'h88);

    locWr(2'd1, 8'h5A);
    stsChk("R5 ODR write sets OBF", 8'h89);
    hostRd(16'h0CA2, v);
    chk("R5 host data read", v, 8'h5A);
    stsChk("R5 host read clears OBF", 8'h88);

    @(negedge clk); irqEnable = 1'b1;
    hostWr(16'h0CA2, 8'h33);
    chk("R9 irq with IBF and enable", {7'd0, irq}, 8'h01);
    irqEnable = 1'b0;
    @(negedge clk);
    chk("R9 irq masked", {7'd0, irq}, 8'h00);
    irqEnable = 1'b1;
    @(negedge clk);
    chk("R9 irq unmasked", {7'd0, irq}, 8'h01);
    locRd(2'd0, v);
    chk("R9 irq drops with IBF", {7'd0, irq}, 8'h00);
    stsChk("R9 status", 8'h80);

    @(negedge clk); chanEnable = 1'b0;
    hostWr(16'h0CA2, 8'h44);
    stsChk("R10 disabled write ignored", 8'h80);
    locWr(2'd1, 8'h77);
    hostRd(16'h0CA2, v);
    chk("R10 disabled read floats", v, 8'hFF);
    stsChk("R10 OBF kept", 8'h81);
    @(negedge clk); chanEnable = 1'b1;

    hostWr(16'h0CA4, 8'h55);
    stsChk("R11 foreign address ignored", 8'h81);
    @(negedge clk); baseAddr = 16'h0CA8;
    hostWr(16'h0CA8, 8'h66);
    hostWr(16'h0CA2, 8'h99);
    stsChk("R11 new base accepted", 8'h83);
    locRd(2'd0, v);
    chk("R11 old base ignored", v, 8'h66);

    // collision: host write with IDR read
    @(negedge clk);
    hostAddr = 16'h0CA8; hostWrData = 8'hAB; hostWrEn = 1'b1;
    locAddr = 2'd0; locRdEn = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0; locRdEn = 1'b0;
    stsChk("R4 collision IBF stays set", 8'h83);
    locRd(2'd0, v);
    chk("R4 collision new byte", v, 8'hAB);

    // collision: ODR write with host data read
    @(negedge clk);
    locAddr = 2'd1; locWrData = 8'hCD; locWrEn = 1'b1;
    hostAddr = 16'h0CA8; hostRdEn = 1'b1;
    @(negedge clk);
    locWrEn = 1'b0; hostRdEn = 1'b0;
    stsChk("R5 collision OBF stays set", 8'h81);
    hostRd(16'h0CA8, v);
    chk("R5 collision byte", v, 8'hCD);
    hostRd(16'h0CA9, v);
    chk("R6 status at new base", v, 8'h80);

    // reset from busy state
    hostWr(16'h0CA9, 8'h01);
    chk("R9 irq before reset", {7'd0, irq}, 8'h01);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    chk("R1 irq cleared by reset", {7'd0, irq}, 8'h00);
    stsChk("R1 status cleared by reset", 8'h00);

    #5;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule